// File: doc/BRIEF.md
# Smart Card Clock Generator

The block derives the clock for a contact smart card from a reference clock. In asynchronous operation a free-running divider makes the card clock. A two-bit code selects one of three divided rates with an exact 50% duty cycle, or a pass-through of the reference itself. In synchronous operation a strobe from the host controller drives the card clock directly, and the divider output is not used. A buffered copy of the reference is always present on its own output, for example to feed a second card channel.

The host may change the ratio code and the activation sequencer may drop the clock enable at any time. In asynchronous operation both are applied only at the wrap of a three-bit counter, every eight reference cycles. At that point every divided tap has just gone low, so the card never sees a shortened pulse. The pass-through path is gated by an enable register clocked on the falling reference edge, which keeps the gate stable while the reference is high.

Top module: `cardclk_gen`

## Requirements
- R1: With the mode select low and the enable high, code 2'b00 gives the reference divided by 8, 2'b10 divided by 4 and 2'b11 divided by 2. Each of these has a high time of exactly half its period, and card-clock edges fall on rising reference edges.
- R2: Code 2'b01 passes the reference through undivided. The card clock is high during each reference high phase and low during each reference low phase.
- R3: A new ratio code and a new enable level take effect only at the rising reference edge on which the three-bit divider counter wraps from 7 to 0. No card-clock pulse or gap is then shorter than the shorter half period of the old and new ratios.
- R4: With the mode select high, the card clock equals the strobe input ANDed with the enable, with no clock delay.
- R5: With the mode select low, the strobe has no effect on the card clock.
- R6: With the enable low, the card clock is held low. In synchronous mode this is immediate. In asynchronous mode it holds from the next counter wrap, which is at most 8 reference cycles later.
- R7: The buffered reference output equals the reference clock at all times and in every mode.
- R8: Reset clears the counter to 0 and holds the card clock low. After release the block runs at divide-by-8 with the output disabled until the first wrap, on the 8th rising edge. The first card-clock rise can therefore come no earlier than the 9th edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock (crystal or external) |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_sel | input | 2 | Ratio code: 00 /8, 01 /1, 10 /4, 11 /2 |
| sync_mode | input | 1 | High: strobe drives the card clock; low: divider drives it |
| strobe | input | 1 | Host strobe used as card clock in synchronous mode |
| clk_en | input | 1 | Card clock enable from the activation sequencer |
| card_clk | output | 1 | Clock to the card contact |
| ref_buf | output | 1 | Buffered copy of the reference clock |

## Verification
A ratio change and an enable change can both be pending at the same counter wrap, and a ratio change can also land while the pass-through gate is closing on the falling edge. The bench gives random sequences of ratio codes that include pass-through. It samples the card clock at both reference phases across each switch and measures the shortest complete high or low run. That run must not be shorter than the shorter half period of the two ratios. It also toggles the strobe while the divider runs, and the divided waveform must stay unchanged.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;

   typedef enum logic [1:0] {
      RATIO_DIV8 = 2'b00,
      RATIO_PASS = 2'b01,
      RATIO_DIV4 = 2'b10,
      RATIO_DIV2 = 2'b11
   } ratio_e;

   // Counter bit whose toggling gives the selected divided clock.
   function automatic int tap_of(ratio_e r);
      case (r)
         RATIO_DIV2: tap_of = 0;
         RATIO_DIV4: tap_of = 1;
         default:    tap_of = 2;
      endcase
   endfunction

endpackage

// File: rtl/cardclk_ratio_ctl.sv
module cardclk_ratio_ctl
   import cardclk_pkg::*;
#(
   parameter int MAX_DIV = 8,
   localparam int CNT_W = $clog2(MAX_DIV)
)(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [1:0]       sel_i,
   input  logic             en_i,
   output logic [CNT_W-1:0] cnt_o,
   output ratio_e           act_o,
   output logic             en_o,
   output logic             div_o
);

   generate
      if (MAX_DIV != 8) begin : g_bad_div
         $error("cardclk_ratio_ctl: MAX_DIV must be 8");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_nxt;
   logic [CNT_W-1:0] taps;
   logic             wrap;
   ratio_e           act_nxt;
   logic             en_nxt;

   assign wrap    = (cnt_o == {CNT_W{1'b1}});
   assign cnt_nxt = cnt_o + 1'b1;
   assign act_nxt = wrap ? ratio_e'(sel_i) : act_o;
   assign en_nxt  = wrap ? en_i : en_o;

   generate
      for (genvar g = 0; g < CNT_W; g++) begin : g_tap
         assign taps[g] = cnt_nxt[g];
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_o <= '0;
         act_o <= RATIO_DIV8;
         en_o  <= 1'b0;
         div_o <= 1'b0;
      end else begin
         cnt_o <= cnt_nxt;
         act_o <= act_nxt;
         en_o  <= en_nxt;
         div_o <= en_nxt && (act_nxt != RATIO_PASS) && taps[tap_of(act_nxt)];
      end
   end

endmodule

// File: rtl/cardclk_pass_gate.sv
module cardclk_pass_gate
   import cardclk_pkg::*;
(
   input  logic   clk_i,
   input  logic   rst_ni,
   input  ratio_e act_i,
   input  logic   en_i,
   output logic   gated_o
);

   logic open_q;

   // Updated while the reference is low, so the gate never cuts a high phase.
   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) open_q <= 1'b0;
      else         open_q <= en_i && (act_i == RATIO_PASS);
   end

   assign gated_o = clk_i & open_q;

endmodule

// File: rtl/cardclk_out_mux.sv
module cardclk_out_mux (
   input  logic sync_i,
   input  logic strobe_i,
   input  logic en_i,
   input  logic div_i,
   input  logic pass_i,
   output logic clk_o
);

   always_comb begin
      if (sync_i) clk_o = strobe_i & en_i;
      else        clk_o = div_i | pass_i;
   end

endmodule

// File: rtl/cardclk_gen.sv
module cardclk_gen
   import cardclk_pkg::*;
#(
   parameter int MAX_DIV = 8,
   localparam int CNT_W = $clog2(MAX_DIV)
)(
   input  logic       ref_clk,
   input  logic       rst_n,
   input  logic [1:0] div_sel,
   input  logic       sync_mode,
   input  logic       strobe,
   input  logic       clk_en,
   output logic       card_clk,
   output logic       ref_buf
);

   logic [CNT_W-1:0] cnt;
   ratio_e           act_sel;
   logic             en_q;
   logic             div_q;
   logic             pass_clk;

   cardclk_ratio_ctl #(.MAX_DIV(MAX_DIV)) u_ctl (
      .clk_i  (ref_clk),
      .rst_ni (rst_n),
      .sel_i  (div_sel),
      .en_i   (clk_en),
      .cnt_o  (cnt),
      .act_o  (act_sel),
      .en_o   (en_q),
      .div_o  (div_q)
   );

   cardclk_pass_gate u_pass (
      .clk_i   (ref_clk),
      .rst_ni  (rst_n),
      .act_i   (act_sel),
      .en_i    (en_q),
      .gated_o (pass_clk)
   );

   cardclk_out_mux u_mux (
      .sync_i   (sync_mode),
      .strobe_i (strobe),
      .en_i     (clk_en),
      .div_i    (div_q),
      .pass_i   (pass_clk),
      .clk_o    (card_clk)
   );

   assign ref_buf = ref_clk;

endmodule

// File: rtl/cardclk_chk.sv
module cardclk_chk
   import cardclk_pkg::*;
#(
   parameter int CNT_W = 3
)(
   input logic             ref_clk,
   input logic             rst_n,
   input logic             sync_mode,
   input logic             strobe,
   input logic             clk_en,
   input logic             card_clk,
   input logic [CNT_W-1:0] cnt,
   input ratio_e           act_sel,
   input logic             en_q,
   input logic             div_q
);

   assert_cnt_step_R3: assert property (@(posedge ref_clk) disable iff (!rst_n)
      1'b1 |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

   assert_sel_at_wrap_R3: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (act_sel != $past(act_sel)) |-> ($past(cnt) == {CNT_W{1'b1}}));

   assert_en_at_wrap_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (en_q != $past(en_q)) |-> ($past(cnt) == {CNT_W{1'b1}}));

   assert_taps_low_at_zero_R1: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (cnt == '0) |-> !div_q);

   assert_off_low_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (!sync_mode && !en_q) |-> !card_clk);

   assert_sync_gate_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (sync_mode && !clk_en) |-> !card_clk);

   assert_sync_strobe_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (sync_mode && clk_en && strobe) |-> card_clk);

endmodule

bind cardclk_gen cardclk_chk #(.CNT_W(CNT_W)) u_chk (
   .ref_clk   (ref_clk),
   .rst_n     (rst_n),
   .sync_mode (sync_mode),
   .strobe    (strobe),
   .clk_en    (clk_en),
   .card_clk  (card_clk),
   .cnt       (cnt),
   .act_sel   (act_sel),
   .en_q      (en_q),
   .div_q     (div_q)
);

// File: tb/cardclk_gen_tb.sv
`timescale 1ns/1ps
module cardclk_gen_tb;

   logic       ref_clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] div_sel = 2'b11;
   logic       sync_mode = 1'b0;
   logic       strobe = 1'b0;
   logic       clk_en = 1'b1;
   logic       card_clk;
   logic       ref_buf;

   int checks = 0;
   int errors = 0;
   logic smp [0:127];
   logic bsmp [0:127];

   always #10 ref_clk = ~ref_clk;  // 50 MHz

   cardclk_gen u_dut (
      .ref_clk(ref_clk), .rst_n(rst_n), .div_sel(div_sel),
      .sync_mode(sync_mode), .strobe(strobe), .clk_en(clk_en),
      .card_clk(card_clk), .ref_buf(ref_buf)
   );

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Half-period of a code, counted in half-reference-cycle samples.
   function automatic int half_w(logic [1:0] c);
      case (c)
         2'b00:   half_w = 8;
         2'b01:   half_w = 1;
         2'b10:   half_w = 4;
         default: half_w = 2;
      endcase
   endfunction

   // n cycles: one sample in the high phase, one in the low phase.
   task automatic grab(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge ref_clk);
         #5  smp[2*i] = card_clk;   bsmp[2*i] = ref_buf;
         #10 smp[2*i+1] = card_clk; bsmp[2*i+1] = ref_buf;
      end
   endtask

   function automatic int high_cnt(int n);
      high_cnt = 0;
      for (int i = 0; i < n; i++) high_cnt += smp[i];
   endfunction

   function automatic int rises_circ(int n);
      rises_circ = 0;
      for (int i = 0; i < n; i++)
         if (!smp[i] && smp[(i+1)%n]) rises_circ++;
   endfunction

   function automatic int min_inner_run(int n);
      int first_end, run, best;
      first_end = -1; run = 0; best = 1000;
      for (int i = 1; i < n; i++) begin
         if (smp[i] != smp[i-1]) begin
            if (first_end >= 0 && run < best) best = run;
            first_end = i; run = 1;
         end else begin
            run++;
         end
      end
      min_inner_run = best;
   endfunction

   initial begin
      #(20ns * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [1:0] cur;
      logic [1:0] nxt;
      int lo;
      void'($urandom(32'h5eed_c10c));

      // R8: reset state
      repeat (3) @(posedge ref_clk);
      #5 check("R8 low in reset", card_clk, 0);
      @(negedge ref_clk); rst_n = 1'b1;
      grab(8);
      check("R8 low until first wrap", high_cnt(16), 0);
      grab(2);
      check("R8 first rise on 9th edge", smp[0], 1);

      // R1/R2: steady-state shape for each code; R7 buffered reference
      for (int k = 0; k < 4; k++) begin
         cur = 2'(k);
         div_sel = cur;
         grab(16);
         grab(16);
         check($sformatf("R1/R2 high half code %0d", k), high_cnt(32), 16);
         check($sformatf("R1/R2 rises code %0d", k), rises_circ(32), 16 / half_w(cur));
         if (cur == 2'b01) begin
            lo = 0;
            for (int i = 0; i < 32; i += 2) lo += (smp[i] == 1'b1 && smp[i+1] == 1'b0);
            check("R2 follows reference phases", lo, 16);
         end
         lo = 0;
         for (int i = 0; i < 32; i++) lo += (bsmp[i] == ((i % 2) == 0));
         check("R7 buffered reference", lo, 32);
      end

      // R3: random ratio switches, no short pulse or gap
      cur = div_sel;
      for (int t = 0; t < 16; t++) begin
         nxt = 2'($urandom_range(0, 3));
         if (t == 0) nxt = 2'b01;
         if (t == 1) nxt = 2'b00;
         div_sel = nxt;
         grab(48);
         lo = (half_w(cur) < half_w(nxt)) ? half_w(cur) : half_w(nxt);
         check($sformatf("R3 min run %0d->%0d", cur, nxt),
               (min_inner_run(96) >= lo) ? 1 : 0, 1);
         cur = nxt;
      end

      // R5: strobe toggling in async mode leaves divide-by-4 intact
      div_sel = 2'b10;
      grab(16);
      fork
         grab(16);
         for (int i = 0; i < 64; i++) #7 strobe = 1'($urandom);
      join
      check("R5 strobe ignored high half", high_cnt(32), 16);
      check("R5 strobe ignored rises", rises_circ(32), 4);

      // R6: async disable takes hold within one wrap
      div_sel = 2'b11;
      grab(16);
      clk_en = 1'b0;
      grab(9);
      grab(16);
      check("R6 async disabled low", high_cnt(32), 0);

      // R4/R6: synchronous strobe path
      sync_mode = 1'b1;
      for (int i = 0; i < 24; i++) begin
         @(posedge ref_clk);
         #2 strobe = 1'($urandom);
         if (i == 12) clk_en = 1'b1;
         #2 check(clk_en ? "R4 strobe drives card clock" : "R6 sync disabled low",
                  card_clk, strobe & clk_en);
      end
      @(negedge ref_clk); strobe = 1'b1; clk_en = 1'b0;
      #1 check("R6 sync disable immediate", card_clk, 0);
      clk_en = 1'b1;
      #1 check("R4 sync enable immediate", card_clk, 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule